// File: doc/BRIEF.md
# Delayed Negative-Operand Branch Controller

This block is the next-PC and flush-control unit of a small 32-bit in-order core. It handles one instruction family: a branch whose condition is that a register operand is negative, and whose target is the current PC plus an immediate offset. Each branch can optionally carry a delay slot. Each cycle the unit may consume one instruction word. It is given the word, the PC of that word and the value of the branch operand. From these it produces the PC to fetch next, a one-cycle squash for the wrong-path word, and stall cycles that stretch a taken branch to its required latency.

A 16-bit immediate-prefix word that comes directly before an instruction supplies the upper half of a full 32-bit offset. Without such a prefix, the branch immediate is sign-extended. While a delayed branch waits for its slot instruction, an interrupt-enable gate output is held low, so that interrupt and break requests stay pending. A slot that holds an instruction which must never go there is reported on an illegal-slot output.

Top module: `negbr_ctl`

## Requirements
- R1: While `rst_ni` is low and on the first cycle after it, `next_pc_o` is 0, `stall_o`, `squash_o` and `illegal_slot_o` are 0, `irq_gate_o` is 1, and no prefix or delay slot is pending.
- R2: An instruction is consumed on a rising edge where `instr_valid_i` is 1 and `stall_o` is 0. After a consumed non-branch or a not-taken branch at PC p, `next_pc_o` is p+4 from the next cycle and no stall or squash is raised.
- R3: The branch is taken only when `ra_i`, read as signed, is below zero (bit 31 set). A zero or positive operand is not taken.
- R4: With no pending prefix, the offset is the 16-bit immediate in bits 15:0, sign-extended to 32 bits, and the target is PC plus that offset.
- R5: A consumed prefix word (bits 31:26 = 101100) stores its bits 15:0. That stored half becomes offset bits 31:16, with the branch immediate as bits 15:0 and no sign extension. The stored prefix is dropped once the next instruction is consumed, whatever that instruction is.
- R6: A taken branch with the delay flag (bit 25) clear sets `next_pc_o` to the target, pulses `squash_o` for one cycle, and holds `stall_o` for 2 cycles, for a total latency of 3 cycles.
- R7: A taken branch with the delay flag set sets `next_pc_o` to p+4, raises no squash, and holds `stall_o` for 1 cycle, for a total latency of 2 cycles. The next consumed instruction is the slot, and after it `next_pc_o` becomes the target.
- R8: Instructions presented while `stall_o` is 1 are ignored, and `next_pc_o` does not change.
- R9: When the slot instruction has bits 31:26 equal to 101100, 100110, 100111, 101110 or 101111 (a prefix, branch or break), `illegal_slot_o` is 1 for the cycle after it is consumed. The slot still redirects to the target and is not captured as a prefix.
- R10: `irq_gate_o` is 0 from the cycle after a taken delayed branch through the cycle in which its slot is consumed, and 1 otherwise.
- R11: A word is decoded as this branch only when bits 31:26 are 101111 and bits 24:21 are 0010. Any other word is handled as a non-branch, even when its operand is negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction word present this cycle |
| instr_i | input | 32 | Instruction word |
| pc_i | input | 32 | PC of the instruction word |
| ra_i | input | 32 | Branch operand value |
| next_pc_o | output | 32 | PC to fetch next |
| squash_o | output | 1 | Kill the wrong-path word fetched after a non-delayed taken branch |
| stall_o | output | 1 | Extra latency cycle; the input word is not consumed |
| illegal_slot_o | output | 1 | Forbidden instruction found in a delay slot |
| irq_gate_o | output | 1 | Interrupts and breaks may be taken when 1 |

## Verification
The properties assume that `instr_valid_i`, `instr_i` and `pc_i` are known at every rising edge. They also assume that a word is only counted as consumed when `stall_o` is low, so `pc_i` during a stall cycle carries no meaning. The stimulus drives every input on the falling edge and keeps `instr_valid_i` high through the stall cycles, with unrelated words, so that the ignore rule is exercised. The random stream uses only aligned PCs and spreads operand signs evenly. It mixes prefixes, delayed and non-delayed branches and forbidden slot words, so each ordering that the properties cover actually occurs.

// File: rtl/negbr_pkg.sv
package negbr_pkg;
  localparam int XLEN  = 32;
  localparam int IMM_W = 16;
  localparam int OP_W  = 6;
  localparam int CC_W  = 4;

  localparam logic [OP_W-1:0] OP_BRI_CC = 6'b101111;
  localparam logic [OP_W-1:0] OP_PFX    = 6'b101100;
  localparam logic [OP_W-1:0] OP_BR_R   = 6'b100110;
  localparam logic [OP_W-1:0] OP_BR_RC  = 6'b100111;
  localparam logic [OP_W-1:0] OP_BRI    = 6'b101110;
  localparam logic [CC_W-1:0] CC_LT     = 4'b0010;

  typedef struct packed {
    logic             is_br;
    logic             is_pfx;
    logic             slot_bad;
    logic             dly;
    logic [IMM_W-1:0] imm;
  } dec_t;
endpackage

// File: rtl/negbr_decode.sv
module negbr_decode
  import negbr_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] instr_i,
  output dec_t         dec_o
);
  localparam int OP_LSB = W - OP_W;
  localparam int D_BIT  = OP_LSB - 1;
  localparam int CC_LSB = D_BIT - CC_W;

  logic [OP_W-1:0] op;
  logic [CC_W-1:0] cc;

  assign op = instr_i[W-1:OP_LSB];
  assign cc = instr_i[D_BIT-1:CC_LSB];

  always_comb begin
    dec_o.is_br    = (op == OP_BRI_CC) && (cc == CC_LT);
    dec_o.is_pfx   = (op == OP_PFX);
    dec_o.slot_bad = (op == OP_PFX) || (op == OP_BR_R) || (op == OP_BR_RC) ||
                     (op == OP_BRI) || (op == OP_BRI_CC);
    dec_o.dly      = instr_i[D_BIT];
    dec_o.imm      = instr_i[IMM_W-1:0];
  end
endmodule

// File: rtl/negbr_target.sv
module negbr_target
  import negbr_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int IW = IMM_W
) (
  input  logic [W-1:0]  pc_i,
  input  logic [W-1:0]  ra_i,
  input  logic          is_br_i,
  input  logic [IW-1:0] imm_i,
  input  logic          pfx_vld_i,
  input  logic [IW-1:0] pfx_hi_i,
  output logic          taken_o,
  output logic [W-1:0]  tgt_o
);
  localparam int CAT_W = 2 * IW;

  logic [W-1:0] off_sext;
  logic [W-1:0] off_cat;
  logic [W-1:0] off;

  assign off_sext = {{(W-IW){imm_i[IW-1]}}, imm_i};

  generate
    if (W > CAT_W) begin : g_cat_wide
      assign off_cat = {{(W-CAT_W){pfx_hi_i[IW-1]}}, pfx_hi_i, imm_i};
    end else begin : g_cat_fit
      logic [CAT_W-1:0] cat;
      assign cat     = {pfx_hi_i, imm_i};
      assign off_cat = cat[W-1:0];
    end
  endgenerate

  assign off     = pfx_vld_i ? off_cat : off_sext;
  assign tgt_o   = pc_i + off;
  assign taken_o = is_br_i && ra_i[W-1];
endmodule

// File: rtl/negbr_seq.sv
module negbr_seq
  import negbr_pkg::*;
#(
  parameter int W          = XLEN,
  parameter int IW         = IMM_W,
  parameter int LAT_SLOT   = 2,
  parameter int LAT_NOSLOT = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [W-1:0]  pc_i,
  input  dec_t          dec_i,
  input  logic          taken_i,
  input  logic [W-1:0]  tgt_i,
  output logic          pfx_vld_o,
  output logic [IW-1:0] pfx_hi_o,
  output logic [W-1:0]  next_pc_o,
  output logic          squash_o,
  output logic          stall_o,
  output logic          illegal_o,
  output logic          irq_gate_o
);
  localparam int MAX_LAT = (LAT_NOSLOT > LAT_SLOT) ? LAT_NOSLOT : LAT_SLOT;
  localparam int CNT_W   = (MAX_LAT > 2) ? $clog2(MAX_LAT) : 1;
  localparam logic [CNT_W-1:0] STALL_SLOT   = CNT_W'(LAT_SLOT - 1);
  localparam logic [CNT_W-1:0] STALL_NOSLOT = CNT_W'(LAT_NOSLOT - 1);
  localparam logic [W-1:0]     PC_STEP      = W'(4);

  logic [CNT_W-1:0] stall_cnt;
  logic             slot_pend;
  logic [W-1:0]     slot_tgt;
  logic             consume;

  assign stall_o    = (stall_cnt != '0);
  assign consume    = valid_i && !stall_o;
  assign irq_gate_o = !slot_pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stall_cnt <= '0;
      slot_pend <= 1'b0;
      slot_tgt  <= '0;
      pfx_vld_o <= 1'b0;
      pfx_hi_o  <= '0;
      next_pc_o <= '0;
      squash_o  <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      squash_o  <= 1'b0;
      illegal_o <= 1'b0;
      if (stall_o) begin
        stall_cnt <= stall_cnt - 1'b1;
      end else if (consume) begin
        pfx_vld_o <= 1'b0;
        if (slot_pend) begin
          // slot retires: redirect, never capture
          slot_pend <= 1'b0;
          next_pc_o <= slot_tgt;
          illegal_o <= dec_i.slot_bad;
        end else if (taken_i && dec_i.dly) begin
          slot_pend <= 1'b1;
          slot_tgt  <= tgt_i;
          next_pc_o <= pc_i + PC_STEP;
          stall_cnt <= STALL_SLOT;
        end else if (taken_i) begin
          next_pc_o <= tgt_i;
          squash_o  <= 1'b1;
          stall_cnt <= STALL_NOSLOT;
        end else begin
          next_pc_o <= pc_i + PC_STEP;
          if (dec_i.is_pfx) begin
            pfx_vld_o <= 1'b1;
            pfx_hi_o  <= dec_i.imm;
          end
        end
      end
    end
  end
endmodule

// File: rtl/negbr_ctl.sv
module negbr_ctl
  import negbr_pkg::*;
#(
  parameter int W          = XLEN,
  parameter int IW         = IMM_W,
  parameter int LAT_SLOT   = 2,
  parameter int LAT_NOSLOT = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         instr_valid_i,
  input  logic [W-1:0] instr_i,
  input  logic [W-1:0] pc_i,
  input  logic [W-1:0] ra_i,
  output logic [W-1:0] next_pc_o,
  output logic         squash_o,
  output logic         stall_o,
  output logic         illegal_slot_o,
  output logic         irq_gate_o
);
  dec_t          dec;
  logic          taken;
  logic [W-1:0]  tgt;
  logic          pfx_vld;
  logic [IW-1:0] pfx_hi;

  negbr_decode #(.W(W)) u_dec (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  negbr_target #(.W(W), .IW(IW)) u_tgt (
    .pc_i      (pc_i),
    .ra_i      (ra_i),
    .is_br_i   (dec.is_br),
    .imm_i     (dec.imm),
    .pfx_vld_i (pfx_vld),
    .pfx_hi_i  (pfx_hi),
    .taken_o   (taken),
    .tgt_o     (tgt)
  );

  negbr_seq #(
    .W(W), .IW(IW), .LAT_SLOT(LAT_SLOT), .LAT_NOSLOT(LAT_NOSLOT)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (instr_valid_i),
    .pc_i       (pc_i),
    .dec_i      (dec),
    .taken_i    (taken),
    .tgt_i      (tgt),
    .pfx_vld_o  (pfx_vld),
    .pfx_hi_o   (pfx_hi),
    .next_pc_o  (next_pc_o),
    .squash_o   (squash_o),
    .stall_o    (stall_o),
    .illegal_o  (illegal_slot_o),
    .irq_gate_o (irq_gate_o)
  );
endmodule

// File: rtl/negbr_ctl_chk.sv
module negbr_ctl_chk #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         instr_valid_i,
  input logic [W-1:0] instr_i,
  input logic [W-1:0] pc_i,
  input logic [W-1:0] next_pc_o,
  input logic         squash_o,
  input logic         stall_o,
  input logic         illegal_slot_o,
  input logic         irq_gate_o
);
  // R6: squash is a single-cycle pulse inside a stall
  assert_squash_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_o |=> !squash_o);
  assert_squash_stalls_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_o |-> stall_o);
  // R7: a pending delayed branch never squashes
  assert_slot_no_squash_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_gate_o |-> !squash_o);
  // R8: stalled input is ignored
  assert_stall_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> $stable(next_pc_o));
  // R9: illegal flag only right after a slot retires
  assert_illegal_after_slot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_slot_o |-> ($past(!irq_gate_o) && irq_gate_o));
  // R2: plain word advances by 4
  assert_plain_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && !stall_o && irq_gate_o && instr_i[W-1:W-6] != 6'b101111)
    |=> (next_pc_o == $past(pc_i) + W'(4)));
  // R10: gate drops only when a stall starts
  assert_gate_fall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_gate_o) |-> stall_o);
endmodule

bind negbr_ctl negbr_ctl_chk #(.W(W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .instr_valid_i  (instr_valid_i),
  .instr_i        (instr_i),
  .pc_i           (pc_i),
  .next_pc_o      (next_pc_o),
  .squash_o       (squash_o),
  .stall_o        (stall_o),
  .illegal_slot_o (illegal_slot_o),
  .irq_gate_o     (irq_gate_o)
);

// File: tb/negbr_ctl_bench.sv
module negbr_ctl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        instr_valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [31:0] pc_i = '0;
  logic [31:0] ra_i = '0;
  logic [31:0] next_pc_o;
  logic        squash_o, stall_o, illegal_slot_o, irq_gate_o;

  int checks = 0;
  int errors = 0;

  // model state
  bit          m_pfx = 0;
  logic [15:0] m_hi = '0;
  bit          m_slot = 0;
  logic [31:0] m_tgt = '0;
  logic [31:0] exp_pc = '0;

  always #10 clk_i = ~clk_i;

  negbr_ctl u_negbr_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .instr_valid_i(instr_valid_i),
    .instr_i(instr_i), .pc_i(pc_i), .ra_i(ra_i), .next_pc_o(next_pc_o),
    .squash_o(squash_o), .stall_o(stall_o), .illegal_slot_o(illegal_slot_o),
    .irq_gate_o(irq_gate_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_br(input bit d, input logic [15:0] imm);
    return {6'b101111, d, 4'b0010, 5'd3, imm};
  endfunction
  function automatic logic [31:0] mk_pfx(input logic [15:0] hi);
    return {6'b101100, 10'd0, hi};
  endfunction
  function automatic bit is_bad(input logic [31:0] w);
    logic [5:0] op = w[31:26];
    return op == 6'b101100 || op == 6'b100110 || op == 6'b100111 ||
           op == 6'b101110 || op == 6'b101111;
  endfunction
  function automatic logic [31:0] mk_plain();
    logic [31:0] w = $urandom();
    if (is_bad(w)) w[31:26] = 6'b000000;
    return w;
  endfunction

  // send one word at the current falling edge and check its result
  task automatic send(input logic [31:0] w, input logic [31:0] pc, input logic [31:0] ra,
                      input string req);
    int ns = 0;
    bit sq = 0, ill = 0;
    bit br = (w[31:26] == 6'b101111) && (w[24:21] == 4'b0010);
    logic [31:0] off, tgt;
    off = m_pfx ? {m_hi, w[15:0]} : {{16{w[15]}}, w[15:0]};
    tgt = pc + off;
    instr_i = w; pc_i = pc; ra_i = ra; instr_valid_i = 1'b1;
    if (m_slot) begin
      exp_pc = m_tgt; ill = is_bad(w); m_slot = 0; m_pfx = 0;
    end else if (br && ra[31]) begin
      m_pfx = 0;
      if (w[25]) begin exp_pc = pc + 4; m_slot = 1; m_tgt = tgt; ns = 1; end
      else begin exp_pc = tgt; sq = 1; ns = 2; end
    end else begin
      exp_pc = pc + 4;
      m_pfx = (w[31:26] == 6'b101100);
      m_hi = w[15:0];
    end
    @(negedge clk_i);
    chk({req, " next_pc"}, next_pc_o, exp_pc);
    chk({req, " squash"}, 32'(squash_o), 32'(sq));
    chk({req, " stall"}, 32'(stall_o), 32'(ns > 0));
    chk({req, " illegal R9"}, 32'(illegal_slot_o), 32'(ill));
    chk({req, " gate R10"}, 32'(irq_gate_o), 32'(!m_slot));
    for (int i = 0; i < ns; i++) begin
      instr_i = mk_br(1'b0, 16'h0040); pc_i = $urandom() & ~32'h3; ra_i = 32'hFFFF_FFFF;
      @(negedge clk_i);
      chk("R8 stall hold", next_pc_o, exp_pc);
      chk("R6/R7 stall length", 32'(stall_o), 32'(i + 1 < ns));
      chk("R6 squash pulse", 32'(squash_o), 32'(0));
    end
    instr_valid_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0b1d));
    repeat (3) @(negedge clk_i);
    chk("R1 reset pc", next_pc_o, 32'h0);
    chk("R1 reset flags", {29'd0, squash_o, stall_o, illegal_slot_o}, 32'h0);
    chk("R1 reset gate", 32'(irq_gate_o), 32'h1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after reset pc", next_pc_o, 32'h0);

    send(mk_plain(), 32'h100, 32'h8000_0000, "R2 plain");
    send(mk_br(0, 16'h0040), 32'h104, 32'h0, "R3 zero not taken");
    send(mk_br(0, 16'h0040), 32'h108, 32'h7FFF_FFFF, "R3 positive not taken");
    send(mk_br(0, 16'hFFF0), 32'h200, 32'h8000_0001, "R4 R6 neg imm no slot");
    send(mk_br(1, 16'h0020), 32'h300, 32'hFFFF_FFFF, "R7 delayed");
    send(mk_plain(), 32'h304, 32'h0, "R7 slot retire");
    send(mk_pfx(16'h1234), 32'h400, 32'h0, "R5 prefix");
    send(mk_br(0, 16'h8000), 32'h404, 32'hF000_0000, "R5 prefixed target");
    send(mk_pfx(16'h0001), 32'h500, 32'h0, "R5 prefix");
    send(mk_plain(), 32'h504, 32'h0, "R5 prefix consumer");
    send(mk_br(0, 16'hFFFC), 32'h508, 32'h8000_0000, "R5 prefix dropped");
    send(mk_br(1, 16'h0100), 32'h600, 32'h8000_0000, "R9 delayed");
    send(mk_br(0, 16'h0010), 32'h604, 32'h8000_0000, "R9 branch in slot");
    send(mk_br(1, 16'h0100), 32'h700, 32'h8000_0000, "R9 delayed");
    send(mk_pfx(16'hABCD), 32'h704, 32'h0, "R9 prefix in slot");
    send(mk_br(0, 16'h0010), 32'h708, 32'h8000_0000, "R9 slot prefix not kept");
    send({6'b101111, 1'b0, 4'b0011, 5'd0, 16'h0080}, 32'h800, 32'h8000_0000,
         "R11 other cond");
    send({6'b101110, 1'b0, 4'b0010, 5'd0, 16'h0080}, 32'h804, 32'h8000_0000,
         "R11 other opcode");
    // idle cycle: pc must hold
    @(negedge clk_i);
    chk("R2 idle hold", next_pc_o, exp_pc);

    for (int n = 0; n < 400; n++) begin
      int k = $urandom_range(0, 9);
      logic [31:0] pc = {$urandom_range(0, 32'h3FFF_FFFF), 2'b00};
      logic [31:0] ra = $urandom();
      logic [31:0] w;
      if (k < 3) w = mk_plain();
      else if (k < 5) w = mk_pfx(16'($urandom()));
      else w = mk_br(k[0], 16'($urandom()));
      send(w, pc, ra, "R2-R10 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule